// File: doc/BRIEF.md
# Converter Channel Status Unit

This unit supplies three status flags per channel for a two-channel converter front end, and it keeps the per-channel sample-time setting that the slow, low-power clock domain uses. When the bus writes a sample-time value, the value is handed across into the slow domain through a toggle request and acknowledge handshake. A busy flag stays high for the whole hand-over, and any further write made while it is high is dropped and reported with a one-cycle error pulse. Turning on the sample-and-hold enable also starts a hand-over, which carries the value already held.

Each channel also has a sticky DMA underrun flag. The flag sets when a conversion trigger arrives while the DMA request raised by the previous trigger is still unacknowledged. A bus write that carries a one in the flag's bit clears it. The third flag is a live comparison between the calibration trim value and the offset correction value. All flags are gathered into one 32-bit status word, with a 16-bit lane for each channel.

Top module: `cvt_stat_unit`

## Requirements
- R1: After reset the status word is 0, both error pulses are 0 and both slow-domain sample-time values are 0.
- R2: A channel's busy flag (status bit 15 for channel 0, bit 31 for channel 1) reads 1 one clock cycle after a rising edge of that channel's sample-and-hold enable, or one cycle after a write to that channel that is accepted because busy was 0.
- R3: Busy returns to 0 through the handshake alone, no sooner than 2 slow-clock periods minus one fast cycle and no later than 3 slow-clock periods plus 4 fast cycles after it set.
- R4: Each accepted write value appears on the channel's slow-domain output, in write order, no later than the cycle in which busy returns to 0.
- R5: A write made while busy is 1 is dropped: the slow-domain value keeps the earlier write, and the channel's error output is 1 in the next cycle only.
- R6: The underrun flag (bit 13 for channel 0, bit 29 for channel 1) reads 1 one cycle after a trigger arrives while the previous trigger's request is still open. A DMA acknowledge closes the request, and an acknowledge in the same cycle as a trigger counts as service, so no underrun is raised.
- R7: A status write with a 1 in a channel's underrun bit position clears that flag one cycle later. A 0 in that position leaves the flag unchanged, and without a clear the flag holds.
- R8: When an underrun is detected in the same cycle as a clear, the flag reads 1 afterwards.
- R9: The calibration flag (bit 14 for channel 0, bit 30 for channel 1) reads 1 exactly when the channel's trim value is equal to or greater than its offset value, and it follows the inputs without a clock.
- R10: All status bits other than 13 to 15 and 29 to 31 read 0, and activity on one channel leaves the other channel's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| lclk | input | 1 | Slow low-power clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 2 | Per-channel sample-time write strobe |
| wr_data | input | TW | Sample-time value to write |
| sh_en | input | 2 | Per-channel sample-and-hold enable level |
| trig | input | 2 | Per-channel conversion trigger pulse |
| dma_ack | input | 2 | Per-channel DMA acknowledge pulse |
| stat_wr | input | 1 | Status word write strobe (write-one-to-clear) |
| stat_wdata | input | 32 | Status word write data |
| trim | input | 2*CW | Per-channel calibration trim values |
| ofs | input | 2*CW | Per-channel offset correction values |
| status | output | 32 | Combined status word |
| wr_err | output | 2 | One-cycle pulse for a dropped write |
| st_slow | output | 2*TW | Sample-time values held in the slow domain |

## Verification
Writes are made on an idle channel, back to back on a busy channel, and on the two channels in turn, so an accepted value, a dropped value and a value that reached the wrong channel each show up in the slow-domain output. The enable edge is tried without any write, which separates a hand-over started by the enable from one started by a write. Trigger patterns with no acknowledge, with an acknowledge between triggers, and with an acknowledge in the same cycle as a trigger separate a true underrun from a serviced one. Clears with a 0 bit, a 1 bit and a coincident set show the write-one rule and the priority of a set. Trim values above, equal to and below the offset check both sides of the comparison.

// File: rtl/cvt_stat_pkg.sv
`timescale 1ns/1ps
package cvt_stat_pkg;
  localparam int NCH      = 2;
  localparam int LANE     = 16;
  localparam int BUSY_POS = 15;
  localparam int CAL_POS  = 14;
  localparam int UDR_POS  = 13;

  function automatic int busy_bit(input int ch);
    return LANE * ch + BUSY_POS;
  endfunction

  function automatic int cal_bit(input int ch);
    return LANE * ch + CAL_POS;
  endfunction

  function automatic int udr_bit(input int ch);
    return LANE * ch + UDR_POS;
  endfunction

  // trim at or above offset gives 1
  function automatic logic cal_ge(input logic [31:0] t, input logic [31:0] o);
    return (t >= o);
  endfunction
endpackage

// File: rtl/st_xfer.sv
`timescale 1ns/1ps
module st_xfer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lclk,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          sh_en,
  output logic          busy,
  output logic          wr_err,
  output logic          acc_wr,
  output logic          drop_wr,
  output logic [TW-1:0] st_slow
);
  logic          sh_q, sh_rise, start, ack_seen;
  logic          req_tog, ack_s1, ack_s2;
  logic          s_s1, s_s2, s_tog;
  logic [TW-1:0] hold;

  assign sh_rise  = sh_en & ~sh_q;
  assign acc_wr   = wr_en & ~busy;
  assign drop_wr  = wr_en & busy;
  assign start    = acc_wr | (sh_rise & ~busy);
  assign ack_seen = (ack_s2 == req_tog);

  // fast domain: request toggle, held value, busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= 1'b0;
      wr_err  <= 1'b0;
      hold    <= '0;
      req_tog <= 1'b0;
      busy    <= 1'b0;
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
    end else begin
      sh_q   <= sh_en;
      wr_err <= drop_wr;
      ack_s1 <= s_tog;
      ack_s2 <= ack_s1;
      if (acc_wr) hold <= wr_data;
      if (start) begin
        req_tog <= ~req_tog;
        busy    <= 1'b1;
      end else if (busy && ack_seen) begin
        busy <= 1'b0;
      end
    end
  end

  // slow domain: two-flop synchronizer, edge detect, capture
  always_ff @(posedge lclk or negedge rst_n) begin
    if (!rst_n) begin
      s_s1    <= 1'b0;
      s_s2    <= 1'b0;
      s_tog   <= 1'b0;
      st_slow <= '0;
    end else begin
      s_s1  <= req_tog;
      s_s2  <= s_s1;
      s_tog <= s_s2;
      if (s_s2 != s_tog) st_slow <= hold;
    end
  end
endmodule

// File: rtl/udr_flag.sv
`timescale 1ns/1ps
module udr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic dma_ack,
  input  logic clr,
  output logic udr,
  output logic ev
);
  logic pending;

  assign ev = trig & pending & ~dma_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      udr     <= 1'b0;
    end else begin
      if (trig)         pending <= 1'b1;
      else if (dma_ack) pending <= 1'b0;
      if (ev)           udr <= 1'b1;
      else if (clr)     udr <= 1'b0;
    end
  end
endmodule

// File: rtl/calib_cmp.sv
`timescale 1ns/1ps
module calib_cmp import cvt_stat_pkg::*; #(
  parameter int CW = 6
) (
  input  logic [CW-1:0] trim,
  input  logic [CW-1:0] ofs,
  output logic          cal
);
  localparam int PADW = 32 - CW;
  assign cal = cal_ge({{PADW{1'b0}}, trim}, {{PADW{1'b0}}, ofs});
endmodule

// File: rtl/cvt_stat_unit.sv
`timescale 1ns/1ps
module cvt_stat_unit import cvt_stat_pkg::*; #(
  parameter int TW = 8,
  parameter int CW = 6
) (
  input  logic              clk,
  input  logic              lclk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_en,
  input  logic [TW-1:0]     wr_data,
  input  logic [NCH-1:0]    sh_en,
  input  logic [NCH-1:0]    trig,
  input  logic [NCH-1:0]    dma_ack,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  input  logic [NCH*CW-1:0] trim,
  input  logic [NCH*CW-1:0] ofs,
  output logic [31:0]       status,
  output logic [NCH-1:0]    wr_err,
  output logic [NCH*TW-1:0] st_slow
);
  logic [NCH-1:0] busy, udr, cal;
  logic [NCH-1:0] acc_wr, drop_wr, udr_ev, udr_clr;
  logic           unused_wbits;

  assign unused_wbits = ^stat_wdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int UB = udr_bit(c);

    assign udr_clr[c] = stat_wr & stat_wdata[UB];

    st_xfer #(.TW(TW)) u_xfer (
      .clk     (clk),
      .rst_n   (rst_n),
      .lclk    (lclk),
      .wr_en   (wr_en[c]),
      .wr_data (wr_data),
      .sh_en   (sh_en[c]),
      .busy    (busy[c]),
      .wr_err  (wr_err[c]),
      .acc_wr  (acc_wr[c]),
      .drop_wr (drop_wr[c]),
      .st_slow (st_slow[c*TW +: TW])
    );

    udr_flag u_udr (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig[c]),
      .dma_ack (dma_ack[c]),
      .clr     (udr_clr[c]),
      .udr     (udr[c]),
      .ev      (udr_ev[c])
    );

    calib_cmp #(.CW(CW)) u_cal (
      .trim (trim[c*CW +: CW]),
      .ofs  (ofs[c*CW +: CW]),
      .cal  (cal[c])
    );
  end

  always_comb begin
    status = '0;
    for (int c = 0; c < NCH; c++) begin
      status[busy_bit(c)] = busy[c];
      status[cal_bit(c)]  = cal[c];
      status[udr_bit(c)]  = udr[c];
    end
  end
endmodule

// File: rtl/cvt_stat_chk.sv
`timescale 1ns/1ps
module cvt_stat_chk import cvt_stat_pkg::*; #(
  parameter int CW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    wr_en,
  input logic              stat_wr,
  input logic [31:0]       stat_wdata,
  input logic [NCH*CW-1:0] trim,
  input logic [NCH*CW-1:0] ofs,
  input logic [31:0]       status,
  input logic [NCH-1:0]    wr_err,
  input logic [NCH-1:0]    acc_wr,
  input logic [NCH-1:0]    drop_wr,
  input logic [NCH-1:0]    udr_ev
);
  localparam logic [31:0] RSV = 32'h1FFF_1FFF;

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & RSV) == 32'h0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam int BB = busy_bit(c);
    localparam int CB = cal_bit(c);
    localparam int UB = udr_bit(c);

    a_r2_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr[c] |=> status[BB]);

    a_r5_drop_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
      drop_wr[c] |=> wr_err[c]);

    a_r5_err_needs_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_err[c]) |-> ($past(wr_en[c]) && $past(status[BB])));

    a_r7_udr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (status[UB] && !(stat_wr && stat_wdata[UB])) |=> status[UB]);

    a_r7_udr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && stat_wdata[UB] && !udr_ev[c]) |=> !status[UB]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      udr_ev[c] |=> status[UB]);

    a_r9_cal_compare: assert property (@(posedge clk) disable iff (!rst_n)
      status[CB] == (trim[c*CW +: CW] >= ofs[c*CW +: CW]));
  end
endmodule

bind cvt_stat_unit cvt_stat_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .trim       (trim),
  .ofs        (ofs),
  .status     (status),
  .wr_err     (wr_err),
  .acc_wr     (acc_wr),
  .drop_wr    (drop_wr),
  .udr_ev     (udr_ev)
);

// File: tb/cvt_stat_unit_bench.sv
`timescale 1ns/1ps
module cvt_stat_unit_bench;
  localparam int TW = 8;
  localparam int CW = 6;
  localparam int SDIV = 10; // slow period in fast cycles

  logic          clk = 1'b0, lclk = 1'b0, rst_n = 1'b0;
  logic [1:0]    wr_en = '0, sh_en = '0, trig = '0, dma_ack = '0;
  logic [TW-1:0] wr_data = '0;
  logic          stat_wr = 1'b0;
  logic [31:0]   stat_wdata = '0;
  logic [2*CW-1:0] trim = '0, ofs = '0;
  logic [31:0]   status;
  logic [1:0]    wr_err;
  logic [2*TW-1:0] st_slow;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [TW-1:0] exp_q0[$];
  logic [TW-1:0] exp_q1[$];
  logic [TW-1:0] last0 = '0, last1 = '0;

  always #2 clk = ~clk;
  always #20 lclk = ~lclk;

  cvt_stat_unit #(.TW(TW), .CW(CW)) u_cvt_stat_unit (
    .clk(clk), .lclk(lclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sh_en(sh_en), .trig(trig), .dma_ack(dma_ack), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .trim(trim), .ofs(ofs), .status(status),
    .wr_err(wr_err), .st_slow(st_slow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: each change of a slow value pops the next expected write (R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (st_slow[TW-1:0] !== last0) begin
        if (exp_q0.size() == 0) chk("R4 ch0 unexpected", {24'h0, st_slow[TW-1:0]}, {24'h0, last0});
        else chk("R4 ch0 value", {24'h0, st_slow[TW-1:0]}, {24'h0, exp_q0.pop_front()});
        last0 = st_slow[TW-1:0];
      end
      if (st_slow[2*TW-1:TW] !== last1) begin
        if (exp_q1.size() == 0) chk("R4 ch1 unexpected", {24'h0, st_slow[2*TW-1:TW]}, {24'h0, last1});
        else chk("R4 ch1 value", {24'h0, st_slow[2*TW-1:TW]}, {24'h0, exp_q1.pop_front()});
        last1 = st_slow[2*TW-1:TW];
      end
    end
  end

  // driver: one write cycle; accepted writes are pushed to the scoreboard
  task automatic wr(input int c, input logic [TW-1:0] d, input bit expect_ok);
    wr_en[c] = 1'b1;
    wr_data  = d;
    if (expect_ok) begin
      if (c == 0) exp_q0.push_back(d); else exp_q1.push_back(d);
    end
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic wait_idle(input int c, output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      if (!status[16*c+15]) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cyc(input logic [1:0] t, input logic [1:0] a, input bit sw, input logic [31:0] wd);
    trig = t; dma_ack = a; stat_wr = sw; stat_wdata = wd;
    @(negedge clk);
    trig = '0; dma_ack = '0; stat_wr = 1'b0; stat_wdata = '0;
  endtask

  task automatic chk_rsv();
    chk("R10 reserved bits", status & 32'h1FFF_1FFF, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    trim = {6'd0, 6'd0}; ofs = {6'd1, 6'd1};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h0);
    chk("R1 wr_err", {30'h0, wr_err}, 32'h0);
    chk("R1 slow value", {16'h0, st_slow}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 status after release", status, 32'h0);

    // R2/R3 enable edge alone starts a hand-over
    sh_en[0] = 1'b1;
    @(negedge clk);
    chk("R2 busy on enable rise", {31'h0, status[15]}, 32'h1);
    chk("R10 ch1 busy untouched", {31'h0, status[31]}, 32'h0);
    wait_idle(0, n);
    chk("R3 busy clears not too soon", {31'h0, n >= 2*SDIV-1}, 32'h1);
    chk("R3 busy clears in time", {31'h0, n <= 3*SDIV+4}, 32'h1);

    // R2/R4 accepted write on channel 0
    wr(0, 8'h5A, 1);
    chk("R2 busy on write", {31'h0, status[15]}, 32'h1);
    wait_idle(0, n);
    chk("R3 write hand-over time", {31'h0, (n >= 2*SDIV-1) && (n <= 3*SDIV+4)}, 32'h1);
    chk("R4 slow value at idle", {24'h0, st_slow[7:0]}, 32'h5A);

    // R5 write during busy is dropped
    wr(0, 8'h11, 1);
    wr(0, 8'h22, 0);
    chk("R5 error pulse", {31'h0, wr_err[0]}, 32'h1);
    @(negedge clk);
    chk("R5 error one cycle", {31'h0, wr_err[0]}, 32'h0);
    wait_idle(0, n);
    chk("R5 dropped value absent", {24'h0, st_slow[7:0]}, 32'h11);
    chk("R5 no error after", {30'h0, wr_err}, 32'h0);

    // R10 channel 1 independent
    wr(1, 8'hC3, 1);
    chk("R10 ch1 busy set", {31'h0, status[31]}, 32'h1);
    chk("R10 ch0 busy clear", {31'h0, status[15]}, 32'h0);
    wait_idle(1, n);
    chk("R4 ch1 value", {24'h0, st_slow[15:8]}, 32'hC3);
    chk("R10 ch0 value kept", {24'h0, st_slow[7:0]}, 32'h11);
    chk_rsv();

    // R6 underrun: two triggers without acknowledge
    cyc(2'b01, 2'b00, 0, 0);
    chk("R6 single trigger no flag", {31'h0, status[13]}, 32'h0);
    cyc(2'b01, 2'b00, 0, 0);
    chk("R6 flag on second trigger", {31'h0, status[13]}, 32'h1);
    chk("R10 ch1 underrun untouched", {31'h0, status[29]}, 32'h0);
    // R7 write of 0 has no effect, write of 1 clears
    cyc(2'b00, 2'b00, 1, 32'hFFFF_DFFF);
    chk("R7 zero bit keeps flag", {31'h0, status[13]}, 32'h1);
    cyc(2'b00, 2'b00, 1, 32'h0000_2000);
    chk("R7 one bit clears flag", {31'h0, status[13]}, 32'h0);
    // R8 set in same cycle as clear (request still open)
    cyc(2'b01, 2'b00, 1, 32'h0000_2000);
    chk("R8 set wins over clear", {31'h0, status[13]}, 32'h1);
    cyc(2'b00, 2'b01, 0, 0);
    cyc(2'b00, 2'b00, 1, 32'h0000_2000);
    chk("R7 clear after service", {31'h0, status[13]}, 32'h0);
    // R6 acknowledged between triggers
    cyc(2'b01, 2'b00, 0, 0);
    cyc(2'b00, 2'b01, 0, 0);
    cyc(2'b01, 2'b00, 0, 0);
    chk("R6 serviced trigger no flag", {31'h0, status[13]}, 32'h0);
    // R6 acknowledge in same cycle as trigger
    cyc(2'b01, 2'b01, 0, 0);
    chk("R6 same-cycle ack no flag", {31'h0, status[13]}, 32'h0);
    cyc(2'b00, 2'b01, 0, 0);
    // channel 1 underrun
    cyc(2'b10, 2'b00, 0, 0);
    cyc(2'b10, 2'b00, 0, 0);
    chk("R6 ch1 flag", {31'h0, status[29]}, 32'h1);
    chk("R10 ch0 underrun untouched", {31'h0, status[13]}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R7 ch1 flag holds", {31'h0, status[29]}, 32'h1);
    cyc(2'b00, 2'b00, 1, 32'h2000_0000);
    chk("R7 ch1 clear", {31'h0, status[29]}, 32'h0);
    chk_rsv();

    // R9 calibration comparison
    trim = {6'd63, 6'd10}; ofs = {6'd62, 6'd5}; #1;
    chk("R9 above", {30'h0, status[30], status[14]}, 32'h3);
    trim = {6'd0, 6'd7}; ofs = {6'd1, 6'd7}; #1;
    chk("R9 equal and below", {30'h0, status[30], status[14]}, 32'h1);
    trim = {6'd20, 6'd3}; ofs = {6'd20, 6'd9}; #1;
    chk("R9 below and equal", {30'h0, status[30], status[14]}, 32'h2);
    chk_rsv();

    repeat (4 * SDIV) @(negedge clk);
    chk("R4 scoreboard drained", exp_q0.size() + exp_q1.size(), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule